// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which input channel a multi-channel analog converter samples, and it walks a run of consecutive positive channels with one conversion on each. A run begins on a software start pulse or on an event strobe from elsewhere in the chip. When the run begins, the block captures the base channel and the scan count. It then issues one conversion-start pulse per channel. After each conversion-done pulse it moves the channel select up by one, until the last channel in the range has been converted.

The last channel is the base plus the scan count, clipped at the highest channel. When the last conversion completes, the block raises a one-cycle run-complete pulse. The channel select then follows the base register again, so the next trigger repeats the same range. A trigger that arrives during a run does not start anything and sets a sticky overrun flag. Register changes made during a run take effect only at the next trigger.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `conv_start_o`, `run_done_o` and `overrun_o` are all 0.
- R2: While idle, `ch_sel_o` equals the current value of `base_i`.
- R3: A one-cycle pulse on either `sw_start_i` or `evt_start_i` while idle starts a run. The first conversion-start pulse comes one cycle after the trigger edge, with `ch_sel_o` equal to the captured base.
- R4: Each `conv_done_i` pulse while waiting for a conversion, other than the last, raises `ch_sel_o` by exactly one. A new conversion-start pulse follows on the next cycle.
- R5: A run makes exactly `count_i + 1` conversions (fewer when clipped by R6). A count of 0 converts only the base channel.
- R6: The last channel of a run is min(base + count, 15). The 4-bit channel select never wraps past 15.
- R7: `run_done_o` is high for exactly one cycle, on the cycle after the final `conv_done_i`. At that point the block is idle again and `ch_sel_o` shows `base_i`.
- R8: A trigger that arrives while a run is in progress starts no extra conversions. It sets `overrun_o`, which then stays 1 until reset.
- R9: Changes to `base_i` or `count_i` after the trigger do not alter the channels or the number of conversions of the run in progress.
- R10: `conv_start_o` is never high on two consecutive cycles. `ch_sel_o` holds steady from a start pulse until its `conv_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 4 | Base (lowest) positive channel register |
| count_i | input | 4 | Number of channels to scan beyond the base |
| sw_start_i | input | 1 | Software start pulse |
| evt_start_i | input | 1 | Event strobe start pulse |
| conv_done_i | input | 1 | Converter finished the current conversion |
| ch_sel_o | output | 4 | Positive channel select to the converter |
| conv_start_o | output | 1 | One-cycle start pulse per conversion |
| busy_o | output | 1 | A run is in progress |
| run_done_o | output | 1 | One-cycle run-complete pulse |
| overrun_o | output | 1 | Sticky flag: trigger seen during a run |

## Verification
Runs are started with the software pulse and with the event strobe. They use a short range from a mid base, a zero count, and a range that the top channel clips. Comparing the ordered channel list from each run against the scoreboard separates a correct step-by-one from a skip or a wrap, and separates an off-by-one stop from a correct one. One run has its registers rewritten mid-scan, which shows whether the range was captured at the trigger. A second trigger during a run shows whether it is ignored and whether it marks the overrun flag.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int unsigned CH_W_DEF  = 4;
    localparam int unsigned CNT_W_DEF = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig #(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_i,
    output logic             trig_o
);

    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src_i[g];
    end

    assign trig_o = chain[N_SRC];

endmodule

// File: rtl/adc_scan_limit.sv
module adc_scan_limit #(
    parameter int unsigned CH_W  = adc_scan_pkg::CH_W_DEF,
    parameter int unsigned CNT_W = adc_scan_pkg::CNT_W_DEF
) (
    input  logic [CH_W-1:0]  base_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CH_W-1:0]  last_o
);

    localparam int unsigned SUM_W = ((CH_W > CNT_W) ? CH_W : CNT_W) + 1;
    localparam logic [SUM_W-1:0] TOP_CH = SUM_W'((1 << CH_W) - 1);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(base_i) + SUM_W'(count_i);
        if (sum > TOP_CH) begin
            last_o = CH_W'(TOP_CH);
        end else begin
            last_o = CH_W'(sum);
        end
    end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm #(
    parameter int unsigned CH_W = adc_scan_pkg::CH_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_i,
    input  logic [CH_W-1:0] base_i,
    input  logic [CH_W-1:0] last_i,
    input  logic            conv_done_i,
    output logic [CH_W-1:0] cur_o,
    output logic [CH_W-1:0] last_o,
    output logic            busy_o,
    output logic            conv_start_o,
    output logic            run_done_o,
    output logic            overrun_o
);

    import adc_scan_pkg::*;

    typedef struct packed {
        seq_state_e      st;
        logic [CH_W-1:0] cur;
        logic [CH_W-1:0] last;
        logic            overrun;
        logic            done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (trig_i && (s_q.st != SEQ_IDLE)) begin
            s_d.overrun = 1'b1;
        end
        case (s_q.st)
            SEQ_IDLE: begin
                if (trig_i) begin
                    s_d.st   = SEQ_ISSUE;
                    s_d.cur  = base_i;
                    s_d.last = last_i;
                end
            end
            SEQ_ISSUE: begin
                s_d.st = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (conv_done_i) begin
                    if (s_q.cur == s_q.last) begin
                        s_d.st   = SEQ_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cur = s_q.cur + 1'b1;
                        s_d.st  = SEQ_ISSUE;
                    end
                end
            end
            default: begin
                s_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, cur: '0, last: '0, overrun: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_o        = s_q.cur;
    assign last_o       = s_q.last;
    assign busy_o       = (s_q.st != SEQ_IDLE);
    assign conv_start_o = (s_q.st == SEQ_ISSUE);
    assign run_done_o   = s_q.done;
    assign overrun_o    = s_q.overrun;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int unsigned CH_W  = adc_scan_pkg::CH_W_DEF,
    parameter int unsigned CNT_W = adc_scan_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  base_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sw_start_i,
    input  logic             evt_start_i,
    input  logic             conv_done_i,
    output logic [CH_W-1:0]  ch_sel_o,
    output logic             conv_start_o,
    output logic             busy_o,
    output logic             run_done_o,
    output logic             overrun_o
);

    logic            trig_any;
    logic [CH_W-1:0] last_calc;
    logic [CH_W-1:0] last_ch;
    logic [CH_W-1:0] cur_ch;

    adc_scan_trig #(.N_SRC(2)) u_trig (
        .src_i  ({evt_start_i, sw_start_i}),
        .trig_o (trig_any)
    );

    adc_scan_limit #(.CH_W(CH_W), .CNT_W(CNT_W)) u_limit (
        .base_i  (base_i),
        .count_i (count_i),
        .last_o  (last_calc)
    );

    adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_any),
        .base_i       (base_i),
        .last_i       (last_calc),
        .conv_done_i  (conv_done_i),
        .cur_o        (cur_ch),
        .last_o       (last_ch),
        .busy_o       (busy_o),
        .conv_start_o (conv_start_o),
        .run_done_o   (run_done_o),
        .overrun_o    (overrun_o)
    );

    assign ch_sel_o = busy_o ? cur_ch : base_i;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int unsigned CH_W = adc_scan_pkg::CH_W_DEF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trig_any,
    input logic            conv_done_i,
    input logic            conv_start_o,
    input logic            busy_o,
    input logic            run_done_o,
    input logic            overrun_o,
    input logic [CH_W-1:0] ch_sel_o,
    input logic [CH_W-1:0] last_ch
);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R10

    AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_done_i) |=> $stable(ch_sel_o)); // R10

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_start_o && conv_done_i && (ch_sel_o != last_ch))
        |=> (conv_start_o && (ch_sel_o == $past(ch_sel_o) + 1'b1))); // R4

    AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        run_done_o |-> ($past(conv_done_i) && !busy_o)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_done_o |=> !run_done_o); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_any) |=> overrun_o); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R8

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_any     (trig_any),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .run_done_o   (run_done_o),
    .overrun_o    (overrun_o),
    .ch_sel_o     (ch_sel_o),
    .last_ch      (last_ch)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] base_i = '0;
    logic [3:0] count_i = '0;
    logic       sw_start_i = 1'b0;
    logic       evt_start_i = 1'b0;
    logic       conv_done_i = 1'b0;
    logic [3:0] ch_sel_o;
    logic       conv_start_o, busy_o, run_done_o, overrun_o;

    int checks = 0;
    int errors = 0;
    int runs_done = 0;
    int tag_req = 0;
    bit finished = 1'b0;
    logic [3:0] exp_q[$];

    always #10 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_i       (base_i),
        .count_i      (count_i),
        .sw_start_i   (sw_start_i),
        .evt_start_i  (evt_start_i),
        .conv_done_i  (conv_done_i),
        .ch_sel_o     (ch_sel_o),
        .conv_start_o (conv_start_o),
        .busy_o       (busy_o),
        .run_done_o   (run_done_o),
        .overrun_o    (overrun_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // converter model: fixed-latency done pulse
    initial begin
        int lat_cnt;
        lat_cnt = 0;
        forever begin
            @(negedge clk);
            conv_done_i = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) conv_done_i = 1'b1;
            end
            if (conv_start_o) lat_cnt = LAT;
        end
    end

    // monitor: pops expected channels at each start pulse
    initial begin
        logic prev_start;
        logic [3:0] exp_ch;
        prev_start = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && conv_start_o) begin
                check("R10 start width", int'(prev_start), 0);
                if (exp_q.size() == 0) begin
                    check("R8/R5 unexpected conversion", 1, 0);
                end else begin
                    exp_ch = exp_q.pop_front();
                    check("R3/R4/R6/R9 channel", int'(ch_sel_o), int'(exp_ch));
                end
            end
            if (rst_n && run_done_o) begin
                check("R5 all conversions made", exp_q.size(), 0);
                check("R7 select back to base", int'(ch_sel_o), int'(base_i));
                check("R7 idle at done", int'(busy_o), 0);
                runs_done++;
            end
            prev_start = conv_start_o;
        end
    end

    // driver: pushes expected channels, fires trigger
    task automatic run_scan(input logic [3:0] b, input logic [3:0] c,
                            input bit use_evt, input bit change_mid,
                            input bit extra_trig);
        int last;
        int start_runs;
        last = int'(b) + int'(c);
        if (last > 15) last = 15;
        for (int k = int'(b); k <= last; k++) exp_q.push_back(4'(k));
        start_runs = runs_done;
        @(negedge clk);
        base_i = b;
        count_i = c;
        if (use_evt) evt_start_i = 1'b1; else sw_start_i = 1'b1;
        @(negedge clk);
        sw_start_i = 1'b0;
        evt_start_i = 1'b0;
        repeat (3) @(negedge clk);
        if (change_mid) begin
            base_i = ~b;
            count_i = 4'd15;
        end
        if (extra_trig) begin
            sw_start_i = 1'b1;
            @(negedge clk);
            sw_start_i = 1'b0;
        end
        for (int t = 0; t < 400 && runs_done == start_runs; t++) @(negedge clk);
        check("R5 run completed", runs_done - start_runs, 1);
        @(negedge clk);
        check("R7 done pulse one cycle", int'(run_done_o), 0);
        repeat (8) @(negedge clk);
        check("R8 no extra run", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(20 * 100000);
        check("watchdog", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy_o), 0);
        check("R1 start", int'(conv_start_o), 0);
        check("R1 done", int'(run_done_o), 0);
        check("R1 overrun", int'(overrun_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        base_i = 4'd9;
        @(negedge clk);
        check("R2 idle select", int'(ch_sel_o), 9);
        base_i = 4'd2;
        @(negedge clk);
        check("R2 idle select", int'(ch_sel_o), 2);

        run_scan(4'd3, 4'd2, 1'b0, 1'b0, 1'b0); // R3 software start, R4 step
        run_scan(4'd0, 4'd0, 1'b1, 1'b0, 1'b0); // R3 event start, R5 single
        run_scan(4'd13, 4'd7, 1'b0, 1'b0, 1'b0); // R6 clipped
        run_scan(4'd15, 4'd0, 1'b1, 1'b0, 1'b0); // R6 top channel only
        run_scan(4'd5, 4'd3, 1'b0, 1'b1, 1'b0); // R9 mid-run rewrite
        check("R8 no overrun yet", int'(overrun_o), 0);
        run_scan(4'd7, 4'd2, 1'b1, 1'b0, 1'b1); // R8 trigger during run
        check("R8 overrun set", int'(overrun_o), 1);
        run_scan(4'd1, 4'd1, 1'b0, 1'b0, 1'b0); // R8 sticky
        check("R8 overrun sticky", int'(overrun_o), 1);
        summary();
    end

endmodule